// File: doc/BRIEF.md
# Registered Single-Precision Floating-Point Multiplier

This block multiplies two single-precision binary floating-point operands and holds the product in an output register. Each operand arrives as three separate fields: a sign bit, an 8-bit exponent biased by 127, and a 23-bit fraction. The fraction has an implied leading one. The result leaves in the same three-field form. A one-bit command input selects what happens at each rising clock edge. With multiply selected, the register loads the new product. With idle selected, the register keeps its current contents.

The finite datapath restores the hidden bits and forms the full 48-bit significand product. It normalizes that product, rounds to nearest with ties to even, and adjusts the exponent for both the normalization shift and any carry out of rounding. Special operands bypass this datapath and follow a fixed table. That table differs from the usual convention in one place: zero times infinity gives zero. Denormals are not supported. An exponent field of zero always reads as zero. A finite product whose biased exponent falls outside 1 to 254 is not stored. The block raises a one-cycle warning instead and keeps the previous result.

Top module: `fp_mul_reg`

## Requirements
- R1: While rst_ni is low, the sign, exponent, fraction, flags and warning outputs are all zero.
- R2: On an edge where mul_i is 0, the result fields and flags_o keep their values and warn_o is 0 after that edge.
- R3: For two finite nonzero operands, the registered sign is the XOR of the operand signs. The exponent is ea + eb − 127, plus one when the significand product is 2 or more. The fraction is the normalized product rounded to nearest, with ties going to the even fraction.
- R4: When rounding carries out of the 23-bit fraction, the fraction becomes zero and the exponent rises by one more.
- R5: If either operand is NaN (exponent 255, fraction nonzero), the result is sign 0, exponent 255 and fraction 0x400000, with flags_o = 4'b0001.
- R6: An operand with exponent 0 is zero whatever its fraction. If neither operand is NaN and either is zero, the result is exponent 0 and fraction 0, its sign is the XOR of the signs, and flags_o = 4'b1000. This includes zero times infinity in either order.
- R7: If neither operand is NaN or zero and at least one is infinity (exponent 255, fraction 0), the result is exponent 255 and fraction 0, and its sign is the XOR of the signs. flags_o is 4'b0100 for positive and 4'b0010 for negative.
- R8: If a finite product's final biased exponent is below 1 or above 254, warn_o is 1 for the one cycle after that multiply edge. The result fields and flags_o stay unchanged.
- R9: A valid finite product sets flags_o to 4'b0000. At most one flag bit is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mul_i | input | 1 | 1 = multiply, 0 = idle |
| a_sign_i | input | 1 | Sign of operand A |
| a_exp_i | input | 8 | Biased exponent of operand A |
| a_frac_i | input | 23 | Fraction of operand A |
| b_sign_i | input | 1 | Sign of operand B |
| b_exp_i | input | 8 | Biased exponent of operand B |
| b_frac_i | input | 23 | Fraction of operand B |
| res_sign_o | output | 1 | Registered result sign |
| res_exp_o | output | 8 | Registered result exponent |
| res_frac_o | output | 23 | Registered result fraction |
| flags_o | output | 4 | Bit 3 zero, bit 2 +inf, bit 1 −inf, bit 0 NaN |
| warn_o | output | 1 | One-cycle pulse on an out-of-range exponent |

## Verification
The bench checks the product of two fractions that rounds all the way to 2.0. A design that drops the rounding carry would return 1.0 there. It also checks exact half-ulp ties on both sides of the even rule. A truncating rounder would miss one side, and a round-half-up rounder would miss the other.

Zero times infinity is checked in both operand orders, along with a zero that has a nonzero fraction. A design that follows the usual convention would return NaN for the first case. A design that tests the fraction to detect zero would compute a tiny product for the second.

Overflow and underflow products are each followed by an idle cycle. A design that writes the wrapped exponent, or that fails to hold flags and the warning, is exposed there.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  parameter int unsigned DEF_EXP_W  = 8;
  parameter int unsigned DEF_FRAC_W = 23;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } opnd_cls_e;

  // flag bit positions
  localparam int unsigned FLG_ZERO = 3;
  localparam int unsigned FLG_PINF = 2;
  localparam int unsigned FLG_NINF = 1;
  localparam int unsigned FLG_NAN  = 0;
  localparam int unsigned FLG_W    = 4;
endpackage

// File: rtl/fmul_classify.sv
module fmul_classify
  import fmul_pkg::*;
#(
  parameter int unsigned EXP_W  = DEF_EXP_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W
) (
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W-1:0] frac_i,
  output opnd_cls_e         cls_o
);
  always_comb begin
    if (exp_i == '0)      cls_o = CLS_ZERO;   // no denormals
    else if (&exp_i)      cls_o = (frac_i == '0) ? CLS_INF : CLS_NAN;
    else                  cls_o = CLS_NORM;
  end
endmodule

// File: rtl/fmul_sig_mult.sv
module fmul_sig_mult #(
  parameter int unsigned FRAC_W = 23
) (
  input  logic [FRAC_W-1:0] a_frac_i,
  input  logic [FRAC_W-1:0] b_frac_i,
  output logic              norm_o,
  output logic [FRAC_W-1:0] kept_o,
  output logic              guard_o,
  output logic              sticky_o
);
  localparam int unsigned SIG_W  = FRAC_W + 1;
  localparam int unsigned PROD_W = 2 * SIG_W;

  logic [SIG_W-1:0]  sig_a, sig_b;
  logic [PROD_W-1:0] prod, aligned;

  assign sig_a   = {1'b1, a_frac_i};
  assign sig_b   = {1'b1, b_frac_i};
  assign prod    = PROD_W'(sig_a) * PROD_W'(sig_b);
  assign norm_o  = prod[PROD_W-1];
  // put the leading one at PROD_W-1
  assign aligned = norm_o ? prod : (prod << 1);

  assign kept_o   = aligned[PROD_W-2 -: FRAC_W];
  assign guard_o  = aligned[PROD_W-2-FRAC_W];
  assign sticky_o = |aligned[PROD_W-3-FRAC_W:0];
endmodule

// File: rtl/fmul_round.sv
module fmul_round #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  logic [EXP_W-1:0]  a_exp_i,
  input  logic [EXP_W-1:0]  b_exp_i,
  input  logic              norm_i,
  input  logic [FRAC_W-1:0] kept_i,
  input  logic              guard_i,
  input  logic              sticky_i,
  output logic [EXP_W-1:0]  exp_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              in_range_o
);
  localparam int unsigned XW      = EXP_W + 2;
  localparam int unsigned BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int unsigned MAX_EXP = (1 << EXP_W) - 2;

  logic              rnd_up;
  logic [FRAC_W:0]   frac_sum;
  logic [XW-1:0]     exp_full;

  assign rnd_up   = guard_i & (sticky_i | kept_i[0]);
  assign frac_sum = {1'b0, kept_i} + (FRAC_W+1)'(rnd_up);

  // negative values wrap far above MAX_EXP in XW bits
  assign exp_full = XW'(a_exp_i) + XW'(b_exp_i) + XW'(norm_i)
                  + XW'(frac_sum[FRAC_W]) - XW'(BIAS);

  assign in_range_o = (exp_full != '0) && (exp_full <= XW'(MAX_EXP));
  assign exp_o      = exp_full[EXP_W-1:0];
  assign frac_o     = frac_sum[FRAC_W-1:0];
endmodule

// File: rtl/fp_mul_reg.sv
module fp_mul_reg
  import fmul_pkg::*;
#(
  parameter int unsigned EXP_W  = DEF_EXP_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mul_i,
  input  logic              a_sign_i,
  input  logic [EXP_W-1:0]  a_exp_i,
  input  logic [FRAC_W-1:0] a_frac_i,
  input  logic              b_sign_i,
  input  logic [EXP_W-1:0]  b_exp_i,
  input  logic [FRAC_W-1:0] b_frac_i,
  output logic              res_sign_o,
  output logic [EXP_W-1:0]  res_exp_o,
  output logic [FRAC_W-1:0] res_frac_o,
  output logic [FLG_W-1:0]  flags_o,
  output logic              warn_o
);
  localparam logic [FRAC_W-1:0] NAN_FRAC = {1'b1, {(FRAC_W-1){1'b0}}};

  opnd_cls_e         a_cls, b_cls;
  logic              norm, guard, sticky, in_range, sign_x;
  logic [FRAC_W-1:0] kept, fin_frac;
  logic [EXP_W-1:0]  fin_exp;

  logic              nxt_sign, nxt_warn;
  logic [EXP_W-1:0]  nxt_exp;
  logic [FRAC_W-1:0] nxt_frac;
  logic [FLG_W-1:0]  nxt_flags;

  fmul_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
    .exp_i(a_exp_i), .frac_i(a_frac_i), .cls_o(a_cls));
  fmul_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
    .exp_i(b_exp_i), .frac_i(b_frac_i), .cls_o(b_cls));

  fmul_sig_mult #(.FRAC_W(FRAC_W)) u_mult (
    .a_frac_i(a_frac_i), .b_frac_i(b_frac_i),
    .norm_o(norm), .kept_o(kept), .guard_o(guard), .sticky_o(sticky));

  fmul_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
    .a_exp_i(a_exp_i), .b_exp_i(b_exp_i), .norm_i(norm),
    .kept_i(kept), .guard_i(guard), .sticky_i(sticky),
    .exp_o(fin_exp), .frac_o(fin_frac), .in_range_o(in_range));

  assign sign_x = a_sign_i ^ b_sign_i;

  // precedence: NaN, then zero (beats inf), then inf, then finite
  always_comb begin
    nxt_sign  = res_sign_o;
    nxt_exp   = res_exp_o;
    nxt_frac  = res_frac_o;
    nxt_flags = flags_o;
    nxt_warn  = 1'b0;
    if (mul_i) begin
      if (a_cls == CLS_NAN || b_cls == CLS_NAN) begin
        nxt_sign  = 1'b0;
        nxt_exp   = '1;
        nxt_frac  = NAN_FRAC;
        nxt_flags = '0;
        nxt_flags[FLG_NAN] = 1'b1;
      end else if (a_cls == CLS_ZERO || b_cls == CLS_ZERO) begin
        nxt_sign  = sign_x;
        nxt_exp   = '0;
        nxt_frac  = '0;
        nxt_flags = '0;
        nxt_flags[FLG_ZERO] = 1'b1;
      end else if (a_cls == CLS_INF || b_cls == CLS_INF) begin
        nxt_sign  = sign_x;
        nxt_exp   = '1;
        nxt_frac  = '0;
        nxt_flags = '0;
        nxt_flags[sign_x ? FLG_NINF : FLG_PINF] = 1'b1;
      end else if (in_range) begin
        nxt_sign  = sign_x;
        nxt_exp   = fin_exp;
        nxt_frac  = fin_frac;
        nxt_flags = '0;
      end else begin
        nxt_warn  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_sign_o <= 1'b0;
      res_exp_o  <= '0;
      res_frac_o <= '0;
      flags_o    <= '0;
      warn_o     <= 1'b0;
    end else begin
      res_sign_o <= nxt_sign;
      res_exp_o  <= nxt_exp;
      res_frac_o <= nxt_frac;
      flags_o    <= nxt_flags;
      warn_o     <= nxt_warn;
    end
  end

  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mul_i |=> $stable(res_sign_o) && $stable(res_exp_o) && $stable(res_frac_o)
               && $stable(flags_o) && !warn_o);

  a_r8_warn_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_o |-> $stable(res_sign_o) && $stable(res_exp_o) && $stable(res_frac_o)
               && $stable(flags_o));

  a_r5_nan_canon: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[FLG_NAN] |-> (&res_exp_o) && res_frac_o == NAN_FRAC && !res_sign_o);

  a_r6_zero_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[FLG_ZERO] |-> res_exp_o == '0 && res_frac_o == '0);

  a_r7_pinf_form: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[FLG_PINF] |-> (&res_exp_o) && res_frac_o == '0 && !res_sign_o);

  a_r9_flags_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flags_o));
endmodule

// File: tb/tb_fp_mul_reg.sv
module tb_fp_mul_reg;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mul_i = 1'b0;
  logic        a_sign_i = 1'b0, b_sign_i = 1'b0;
  logic [7:0]  a_exp_i = '0, b_exp_i = '0;
  logic [22:0] a_frac_i = '0, b_frac_i = '0;
  logic        res_sign_o, warn_o;
  logic [7:0]  res_exp_o;
  logic [22:0] res_frac_o;
  logic [3:0]  flags_o;

  int checks = 0;
  int fails  = 0;

  // reference state
  bit        m_sign = 0;
  bit [7:0]  m_exp  = 0;
  bit [22:0] m_frac = 0;
  bit [3:0]  m_flags = 0;
  bit        m_warn = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fp_mul_reg dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mul_i(mul_i),
    .a_sign_i(a_sign_i), .a_exp_i(a_exp_i), .a_frac_i(a_frac_i),
    .b_sign_i(b_sign_i), .b_exp_i(b_exp_i), .b_frac_i(b_frac_i),
    .res_sign_o(res_sign_o), .res_exp_o(res_exp_o), .res_frac_o(res_frac_o),
    .flags_o(flags_o), .warn_o(warn_o));

  function automatic void model(input bit mul, input bit [31:0] a, input bit [31:0] b);
    bit a_nan, b_nan, a_zero, b_zero, a_inf, b_inf, sx;
    longint ma, mb, p, top, rem;
    int e;
    m_warn = 0;
    if (!mul) return;
    a_zero = (a[30:23] == 0);
    b_zero = (b[30:23] == 0);
    a_inf  = (a[30:23] == 255) && (a[22:0] == 0);
    b_inf  = (b[30:23] == 255) && (b[22:0] == 0);
    a_nan  = (a[30:23] == 255) && (a[22:0] != 0);
    b_nan  = (b[30:23] == 255) && (b[22:0] != 0);
    sx = a[31] ^ b[31];
    if (a_nan || b_nan) begin
      m_sign = 0; m_exp = 255; m_frac = 23'h400000; m_flags = 4'b0001;
    end else if (a_zero || b_zero) begin
      m_sign = sx; m_exp = 0; m_frac = 0; m_flags = 4'b1000;
    end else if (a_inf || b_inf) begin
      m_sign = sx; m_exp = 255; m_frac = 0; m_flags = sx ? 4'b0010 : 4'b0100;
    end else begin
      ma = longint'(a[22:0]) + (64'd1 << 23);
      mb = longint'(b[22:0]) + (64'd1 << 23);
      p  = ma * mb;
      e  = int'(a[30:23]) + int'(b[30:23]) - 127;
      if (p >= (64'd1 << 47)) e = e + 1;
      else p = p * 2;
      top = p / (64'd1 << 24);
      rem = p % (64'd1 << 24);
      if (rem > (64'd1 << 23) || (rem == (64'd1 << 23) && (top % 2) == 1)) top = top + 1;
      if (top == (64'd1 << 24)) begin
        top = top / 2;
        e = e + 1;
      end
      if (e < 1 || e > 254) m_warn = 1;
      else begin
        m_sign = sx; m_exp = e[7:0]; m_frac = top[22:0]; m_flags = 4'b0000;
      end
    end
  endfunction

  task automatic compare(input string tag);
    bit [36:0] act, exp;
    act = {res_sign_o, res_exp_o, res_frac_o, flags_o, warn_o};
    exp = {m_sign, m_exp, m_frac, m_flags, m_warn};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual s=%0b e=%02h f=%06h fl=%04b w=%0b expected s=%0b e=%02h f=%06h fl=%04b w=%0b",
               tag, act[36], act[35:28], act[27:5], act[4:1], act[0],
               exp[36], exp[35:28], exp[27:5], exp[4:1], exp[0]);
    end
  endtask

  // called at a negedge; result checked at the following negedge
  task automatic step(input bit mul, input bit [31:0] a, input bit [31:0] b, input string tag);
    mul_i = mul;
    {a_sign_i, a_exp_i, a_frac_i} = a;
    {b_sign_i, b_exp_i, b_frac_i} = b;
    model(mul, a, b);
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    compare("R1 reset");
    rst_ni = 1'b1;

    // R3 finite products
    step(1, 32'h3FC00000, 32'h40000000, "R3 1.5*2");
    step(1, 32'h3FC00000, 32'h3FC00000, "R3 1.5*1.5 norm");
    step(1, 32'hC0400000, 32'h40A00000, "R3 -3*5");
    step(1, 32'h3FC00000, 32'h3F800001, "R3 tie odd rounds up");
    step(1, 32'h3FC00000, 32'h3F800003, "R3 tie even stays");
    step(1, 32'h3FAAAAAB, 32'hBF2AAAAB, "R3 sticky");
    step(0, 32'h40000000, 32'h40000000, "R2 idle after finite");
    // R4 rounding carry: (1+2^-23)*(2-2^-22) -> 2.0
    step(1, 32'h3F800001, 32'h3FFFFFFE, "R4 carry");
    step(1, 32'hBF800001, 32'h3FFFFFFE, "R4 carry neg");
    // R5 NaN
    step(1, 32'h7FC00000, 32'h3F800000, "R5 nan*one");
    step(1, 32'h3F800000, 32'hFF800001, "R5 one*nan");
    step(1, 32'h7F800001, 32'h00000000, "R5 nan*zero");
    step(1, 32'h7F800000, 32'hFFFFFFFF, "R5 inf*nan");
    step(0, 32'h3F800000, 32'h3F800000, "R2 idle after nan");
    // R6 zero
    step(1, 32'h00000000, 32'h7F800000, "R6 zero*inf");
    step(1, 32'hFF800000, 32'h00000000, "R6 -inf*zero");
    step(1, 32'h80000005, 32'h40400000, "R6 zero with fraction");
    step(1, 32'h00000000, 32'h80000000, "R6 zero*-zero");
    // R7 infinity
    step(1, 32'h7F800000, 32'h7F800000, "R7 +inf*+inf");
    step(1, 32'h7F800000, 32'hFF800000, "R7 +inf*-inf");
    step(1, 32'hFF800000, 32'hFF800000, "R7 -inf*-inf");
    step(1, 32'hC0000000, 32'h7F800000, "R7 -2*+inf");
    step(0, 32'h3F800000, 32'h3F800000, "R2 idle after inf");
    // R8 range
    step(1, 32'h40400000, 32'h40000000, "R9 valid finite clears flags");
    step(1, 32'h7F000000, 32'h40000000, "R8 overflow");
    step(0, 32'h7F000000, 32'h40000000, "R8 warn one cycle");
    step(1, 32'h00800000, 32'h3F000000, "R8 underflow");
    step(1, 32'h7F7FFFFF, 32'h7F7FFFFF, "R8 overflow max");
    step(1, 32'h00000000, 32'h3F800000, "R6 zero sets flag");
    step(1, 32'h00800000, 32'h80800000, "R8 underflow keeps zero flag");
    step(1, 32'h00800000, 32'h3F800000, "R9 min normal");
    step(1, 32'h7F7FFFFF, 32'h3F800000, "R9 max normal");

    for (int i = 0; i < 60; i++) begin
      bit [31:0] a, b;
      a = $urandom;
      b = $urandom;
      a[30:23] = 8'(1 + ($urandom % 254));
      b[30:23] = 8'(1 + ($urandom % 254));
      step(1, a, b, "R3 random finite");
      if (i % 7 == 0) step(0, b, a, "R2 idle random");
    end

    // R1 reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    m_sign = 0; m_exp = 0; m_frac = 0; m_flags = 0; m_warn = 0;
    #1;
    compare("R1 async reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1, 32'h40000000, 32'h40000000, "R3 after reset");

    finish_run();
  end
endmodule